// File: doc/BRIEF.md
# Triggered Exceptional Measurement Unit

This block adds urgent conversions to a shared converter when a hardware event arrives. It has two modes, and each has its own trigger selector. The single-channel mode converts one chosen channel a power-of-two number of times. The sequence mode converts every channel named in a 7-bit mask once, starting at the lowest bit.

The block asks for each conversion through a request/grant handshake. It then waits for the converter's done pulse before it asks again, so only one conversion is outstanding at a time. Whenever the converter is free, single-channel work goes ahead of sequence work. An outer arbiter lets both modes go ahead of the normal sequencer.

Single-channel results land in a dedicated result register. That register has a valid flag, an overrun flag and an optional wait-for-read mode. Sequence results leave the block on a per-channel write port that feeds the ordinary channel result registers. Each mode has an active flag and a sticky status bit, cleared by a one-cycle clear pulse. Its interrupt line is the status bit gated by an enable input.

Top module: `exm_inject`

## Requirements
- R1: A trigger selector code of 0 or 7 selects no trigger. Code k (1 to 6) selects line `trig_in[k-1]`. A conversion run starts only on a rising edge of the selected line, so a line held high starts one run.
- R2: A single-channel run converts the channel given in `sgl_chan_cfg` exactly 2^`sgl_rep_cfg` times (1 to 128). Channel and count are captured when the run starts.
- R3: A sequence run converts each channel whose bit is set in `seq_mask_cfg` (bit b = channel b) exactly once, in ascending channel order. The mask is captured at start. A trigger with an all-zero mask is ignored.
- R4: A trigger for a mode that is already active has no effect. The run keeps its captured channel, count and mask.
- R5: The block keeps at most one conversion outstanding. `conv_req` stays high with a stable `conv_chan` until `conv_grant`. Whenever a new conversion is chosen and the single-channel mode has work left, it is chosen ahead of the sequence mode.
- R6: Each active flag rises on the cycle after the trigger edge. It falls on the cycle after the done pulse of that run's final conversion.
- R7: Each status bit is set after the run's final conversion completes. A clear pulse resets it, and a set in the same cycle wins over the clear. Each interrupt is the status bit ANDed with its enable.
- R8: Single-channel results never drive the channel write port. Each sequence result drives `chres_we` high for that done cycle, together with the converted channel number and the data.
- R9: Dedicated result register: a read pulse clears valid and overrun. In overwrite mode a new result replaces the data and sets overrun if valid was still set. In wait-for-read mode a new result is dropped while valid is set. A result that arrives together with a read is stored, with overrun cleared.
- R10: After reset the block drives no request, no active flag, no status, no interrupt, no channel write, and an empty, non-overrun result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 6 | Hardware trigger lines |
| sgl_trig_sel | input | 3 | Single-channel trigger select (0/7 none, k selects line k-1) |
| sgl_chan_cfg | input | 3 | Channel for single-channel runs |
| sgl_rep_cfg | input | 3 | Repeat exponent; the run converts 2^value times |
| seq_trig_sel | input | 3 | Sequence trigger select |
| seq_mask_cfg | input | 7 | Sequence channel mask, bit b = channel b |
| sgl_ie | input | 1 | Single-channel interrupt enable |
| seq_ie | input | 1 | Sequence interrupt enable |
| sgl_clr | input | 1 | Clear pulse for single-channel status |
| seq_clr | input | 1 | Clear pulse for sequence status |
| sgl_wait_rd | input | 1 | Wait-for-read mode of the dedicated result register |
| sgl_res_rd | input | 1 | Read pulse of the dedicated result register |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 3 | Channel of the requested conversion |
| conv_grant | input | 1 | Converter accepts the request |
| conv_done | input | 1 | Converter finished the granted conversion |
| conv_data | input | 11 | Conversion result, valid with conv_done |
| sgl_active | output | 1 | Single-channel run in progress |
| seq_active | output | 1 | Sequence run in progress |
| sgl_status | output | 1 | Single-channel completion status |
| seq_status | output | 1 | Sequence completion status |
| sgl_irq | output | 1 | Single-channel interrupt |
| seq_irq | output | 1 | Sequence interrupt |
| sgl_res_data | output | 11 | Dedicated result data |
| sgl_res_valid | output | 1 | Dedicated result holds unread data |
| sgl_res_ovf | output | 1 | Dedicated result was overwritten before being read |
| chres_we | output | 1 | Write strobe to the channel result registers |
| chres_chan | output | 3 | Channel for the channel result write |
| chres_data | output | 11 | Data for the channel result write |

## Verification
The hardest situation to reach is a single-channel trigger that arrives while a sequence run is in progress. The single-channel block must then slot in at the next conversion boundary, and the rest of the mask must still finish in order. To get there, the stimulus starts a full-mask sequence run and waits until the bench's converter model has logged two conversions. It then fires the single-channel trigger. The bench checks that the single-channel conversions form one contiguous block and that the seven sequence channels still appear in ascending order. Random runs also fire both triggers in the same cycle, with random latencies in the converter model. For those runs the bench expects the whole single-channel block to come first.

// File: rtl/exm_pkg.sv
`timescale 1ns/1ps
package exm_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_REQ  = 2'd1,
    ARB_BUSY = 2'd2
  } arb_state_t;

  typedef enum logic {
    SRC_SGL = 1'b0,
    SRC_SEQ = 1'b1
  } arb_src_t;

  // number of conversions for a repeat exponent
  function automatic logic [31:0] rep_to_count(input logic [7:0] rep);
    return 32'd1 << rep;
  endfunction

  // index of the lowest set bit, 0 when none is set
  function automatic logic [31:0] lowest_set(input logic [31:0] m);
    logic [31:0] idx;
    idx = 32'd0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) idx = 32'(i);
    end
    return idx;
  endfunction

  // trigger source decode: 0 and codes above the line count select nothing
  function automatic logic trig_pick(input logic [31:0] edges, input logic [7:0] code,
                                     input logic [7:0] nlines);
    logic [31:0] sh;
    if (code == 8'd0 || code > nlines) return 1'b0;
    sh = edges >> (code - 8'd1);
    return sh[0];
  endfunction

endpackage

// File: rtl/exm_trig_pick.sv
`timescale 1ns/1ps
module exm_trig_pick
  import exm_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 6,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] lines,
  input  logic [SEL_W-1:0]    sel,
  output logic                hit
);

  logic [NUM_TRIG-1:0] prev_q;
  logic [NUM_TRIG-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  assign rise = lines & ~prev_q;
  assign hit  = trig_pick(32'(rise), 8'(sel), 8'(NUM_TRIG));

endmodule

// File: rtl/exm_single_eng.sv
`timescale 1ns/1ps
module exm_single_eng
  import exm_pkg::*;
#(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned REP_W = 3,
  localparam int unsigned CNT_W = (1 << REP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_cfg,
  input  logic [REP_W-1:0] rep_cfg,
  input  logic             done,
  input  logic             clr,
  output logic             active,
  output logic [CH_W-1:0]  chan,
  output logic [CNT_W-1:0] left,
  output logic             finish,
  output logic             status
);

  assign finish = active & done & (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      chan   <= '0;
      left   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      chan   <= chan_cfg;
      left   <= CNT_W'(rep_to_count(8'(rep_cfg)));
    end else if (active && done) begin
      left <= left - CNT_W'(1);
      if (finish) active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= 1'b0;
    else if (finish) status <= 1'b1;
    else if (clr)    status <= 1'b0;
  end

endmodule

// File: rtl/exm_seq_eng.sv
`timescale 1ns/1ps
module exm_seq_eng
  import exm_pkg::*;
#(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned MASK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MASK_W-1:0] mask_cfg,
  input  logic              done,
  input  logic              clr,
  output logic              active,
  output logic [CH_W-1:0]   chan,
  output logic              finish,
  output logic              status
);

  logic [MASK_W-1:0] pend;
  logic [MASK_W-1:0] cur_bit;
  logic [MASK_W-1:0] rest;

  assign chan    = CH_W'(lowest_set(32'(pend)));
  assign cur_bit = MASK_W'(1) << chan;
  assign rest    = pend & ~cur_bit;
  assign finish  = active & done & (rest == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= '0;
    end else if (start && !active && (mask_cfg != '0)) begin
      active <= 1'b1;
      pend   <= mask_cfg;
    end else if (active && done) begin
      pend <= rest;
      if (finish) active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= 1'b0;
    else if (finish) status <= 1'b1;
    else if (clr)    status <= 1'b0;
  end

endmodule

// File: rtl/exm_conv_arb.sv
`timescale 1ns/1ps
module exm_conv_arb
  import exm_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sgl_need,
  input  logic            seq_need,
  input  logic [CH_W-1:0] sgl_chan,
  input  logic [CH_W-1:0] seq_chan,
  input  logic            grant,
  input  logic            done,
  output logic            req,
  output logic [CH_W-1:0] chan,
  output logic            launch,
  output logic            src_sgl,
  output logic            done_sgl,
  output logic            done_seq
);

  arb_state_t st;
  arb_src_t   src;

  assign launch = (st == ARB_IDLE) && (sgl_need || seq_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ARB_IDLE;
      src  <= SRC_SGL;
      chan <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: if (launch) begin
          st   <= ARB_REQ;
          src  <= sgl_need ? SRC_SGL : SRC_SEQ;
          chan <= sgl_need ? sgl_chan : seq_chan;
        end
        ARB_REQ:  if (grant) st <= ARB_BUSY;
        ARB_BUSY: if (done)  st <= ARB_IDLE;
        default:  st <= ARB_IDLE;
      endcase
    end
  end

  assign req      = (st == ARB_REQ);
  assign src_sgl  = (src == SRC_SGL);
  assign done_sgl = (st == ARB_BUSY) && done && (src == SRC_SGL);
  assign done_seq = (st == ARB_BUSY) && done && (src == SRC_SEQ);

endmodule

// File: rtl/exm_result_reg.sv
`timescale 1ns/1ps
module exm_result_reg #(
  parameter int unsigned RES_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [RES_W-1:0] wr_data,
  input  logic             wait_rd,
  input  logic             rd,
  output logic [RES_W-1:0] data,
  output logic             valid,
  output logic             ovf
);

  logic blocked;
  assign blocked = valid && wait_rd && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
      ovf   <= 1'b0;
    end else if (wr && !blocked) begin
      data  <= wr_data;
      valid <= 1'b1;
      ovf   <= valid && !rd;
    end else if (rd) begin
      valid <= 1'b0;
      ovf   <= 1'b0;
    end
  end

endmodule

// File: rtl/exm_inject.sv
`timescale 1ns/1ps
module exm_inject
  import exm_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 6,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned CH_W     = 3,
  parameter int unsigned REP_W    = 3,
  parameter int unsigned MASK_W   = 7,
  parameter int unsigned RES_W    = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sgl_trig_sel,
  input  logic [CH_W-1:0]     sgl_chan_cfg,
  input  logic [REP_W-1:0]    sgl_rep_cfg,
  input  logic [SEL_W-1:0]    seq_trig_sel,
  input  logic [MASK_W-1:0]   seq_mask_cfg,
  input  logic                sgl_ie,
  input  logic                seq_ie,
  input  logic                sgl_clr,
  input  logic                seq_clr,
  input  logic                sgl_wait_rd,
  input  logic                sgl_res_rd,
  output logic                conv_req,
  output logic [CH_W-1:0]     conv_chan,
  input  logic                conv_grant,
  input  logic                conv_done,
  input  logic [RES_W-1:0]    conv_data,
  output logic                sgl_active,
  output logic                seq_active,
  output logic                sgl_status,
  output logic                seq_status,
  output logic                sgl_irq,
  output logic                seq_irq,
  output logic [RES_W-1:0]    sgl_res_data,
  output logic                sgl_res_valid,
  output logic                sgl_res_ovf,
  output logic                chres_we,
  output logic [CH_W-1:0]     chres_chan,
  output logic [RES_W-1:0]    chres_data
);

  localparam int unsigned CNT_W = (1 << REP_W);

  // named internal events
  logic             sgl_hit;
  logic             seq_hit;
  logic [CH_W-1:0]  sgl_chan;
  logic [CH_W-1:0]  seq_chan;
  logic [CNT_W-1:0] sgl_left;
  logic             sgl_finish;
  logic             seq_finish;
  logic             arb_launch;
  logic             arb_src_sgl;
  logic             done_sgl;
  logic             done_seq;

  // one edge detector per mode
  for (genvar m = 0; m < 2; m++) begin : g_trig
    exm_trig_pick #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (trig_in),
      .sel   ((m == 0) ? sgl_trig_sel : seq_trig_sel),
      .hit   ()
    );
  end

  assign sgl_hit = g_trig[0].u_pick.hit;
  assign seq_hit = g_trig[1].u_pick.hit;

  exm_single_eng #(.CH_W(CH_W), .REP_W(REP_W)) u_sgl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sgl_hit),
    .chan_cfg (sgl_chan_cfg),
    .rep_cfg  (sgl_rep_cfg),
    .done     (done_sgl),
    .clr      (sgl_clr),
    .active   (sgl_active),
    .chan     (sgl_chan),
    .left     (sgl_left),
    .finish   (sgl_finish),
    .status   (sgl_status)
  );

  exm_seq_eng #(.CH_W(CH_W), .MASK_W(MASK_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_hit),
    .mask_cfg (seq_mask_cfg),
    .done     (done_seq),
    .clr      (seq_clr),
    .active   (seq_active),
    .chan     (seq_chan),
    .finish   (seq_finish),
    .status   (seq_status)
  );

  exm_conv_arb #(.CH_W(CH_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sgl_need (sgl_active),
    .seq_need (seq_active),
    .sgl_chan (sgl_chan),
    .seq_chan (seq_chan),
    .grant    (conv_grant),
    .done     (conv_done),
    .req      (conv_req),
    .chan     (conv_chan),
    .launch   (arb_launch),
    .src_sgl  (arb_src_sgl),
    .done_sgl (done_sgl),
    .done_seq (done_seq)
  );

  exm_result_reg #(.RES_W(RES_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (done_sgl),
    .wr_data (conv_data),
    .wait_rd (sgl_wait_rd),
    .rd      (sgl_res_rd),
    .data    (sgl_res_data),
    .valid   (sgl_res_valid),
    .ovf     (sgl_res_ovf)
  );

  assign sgl_irq    = sgl_status & sgl_ie;
  assign seq_irq    = seq_status & seq_ie;
  assign chres_we   = done_seq;
  assign chres_chan = seq_chan;
  assign chres_data = conv_data;

endmodule

// File: rtl/exm_inject_chk.sv
`timescale 1ns/1ps
module exm_inject_chk #(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned RES_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_req,
  input logic             conv_grant,
  input logic [CH_W-1:0]  conv_chan,
  input logic             arb_launch,
  input logic             arb_src_sgl,
  input logic             sgl_active,
  input logic             seq_active,
  input logic             sgl_hit,
  input logic             sgl_finish,
  input logic             seq_finish,
  input logic             sgl_status,
  input logic             seq_status,
  input logic [CNT_W-1:0] sgl_left,
  input logic             done_sgl,
  input logic             chres_we,
  input logic             sgl_wait_rd,
  input logic             sgl_res_rd,
  input logic             sgl_res_valid,
  input logic             sgl_res_ovf,
  input logic [RES_W-1:0] sgl_res_data
);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_grant |=> conv_req && $stable(conv_chan));

  p_sgl_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_launch && sgl_active |=> arb_src_sgl);

  p_active_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sgl_active) |-> $past(sgl_hit));

  p_active_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sgl_active) |-> $past(sgl_finish));

  p_sgl_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sgl_finish |=> sgl_status);

  p_seq_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> seq_status);

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sgl_active && !done_sgl |=> $stable(sgl_left));

  p_chres_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chres_we |-> seq_active && !done_sgl);

  p_ovf_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sgl_res_ovf |-> sgl_res_valid);

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sgl_wait_rd && sgl_res_valid && !sgl_res_rd |=> $stable(sgl_res_data));

endmodule

bind exm_inject exm_inject_chk #(.CH_W(CH_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_req      (conv_req),
  .conv_grant    (conv_grant),
  .conv_chan     (conv_chan),
  .arb_launch    (arb_launch),
  .arb_src_sgl   (arb_src_sgl),
  .sgl_active    (sgl_active),
  .seq_active    (seq_active),
  .sgl_hit       (sgl_hit),
  .sgl_finish    (sgl_finish),
  .seq_finish    (seq_finish),
  .sgl_status    (sgl_status),
  .seq_status    (seq_status),
  .sgl_left      (sgl_left),
  .done_sgl      (done_sgl),
  .chres_we      (chres_we),
  .sgl_wait_rd   (sgl_wait_rd),
  .sgl_res_rd    (sgl_res_rd),
  .sgl_res_valid (sgl_res_valid),
  .sgl_res_ovf   (sgl_res_ovf),
  .sgl_res_data  (sgl_res_data)
);

// File: tb/exm_inject_test.sv
`timescale 1ns/1ps
module exm_inject_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  trig_in = '0;
  logic [2:0]  sgl_trig_sel = '0, sgl_chan_cfg = '0, sgl_rep_cfg = '0, seq_trig_sel = '0;
  logic [6:0]  seq_mask_cfg = '0;
  logic        sgl_ie = 0, seq_ie = 0, sgl_clr = 0, seq_clr = 0, sgl_wait_rd = 0, sgl_res_rd = 0;
  logic        conv_req;
  logic [2:0]  conv_chan;
  logic        conv_grant, conv_done;
  logic [10:0] conv_data;
  logic        sgl_active, seq_active, sgl_status, seq_status, sgl_irq, seq_irq;
  logic [10:0] sgl_res_data;
  logic        sgl_res_valid, sgl_res_ovf, chres_we;
  logic [2:0]  chres_chan;
  logic [10:0] chres_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // conversion log kept by the converter model
  logic [2:0]  log_chan [256];
  logic [10:0] log_data [256];
  logic        log_wr   [256];
  logic [2:0]  log_wrch [256];
  logic [10:0] log_wrd  [256];
  int          log_n = 0;

  always #10 clk = ~clk;

  exm_inject uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .sgl_trig_sel(sgl_trig_sel), .sgl_chan_cfg(sgl_chan_cfg), .sgl_rep_cfg(sgl_rep_cfg),
    .seq_trig_sel(seq_trig_sel), .seq_mask_cfg(seq_mask_cfg),
    .sgl_ie(sgl_ie), .seq_ie(seq_ie), .sgl_clr(sgl_clr), .seq_clr(seq_clr),
    .sgl_wait_rd(sgl_wait_rd), .sgl_res_rd(sgl_res_rd),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_grant(conv_grant),
    .conv_done(conv_done), .conv_data(conv_data),
    .sgl_active(sgl_active), .seq_active(seq_active),
    .sgl_status(sgl_status), .seq_status(seq_status),
    .sgl_irq(sgl_irq), .seq_irq(seq_irq),
    .sgl_res_data(sgl_res_data), .sgl_res_valid(sgl_res_valid), .sgl_res_ovf(sgl_res_ovf),
    .chres_we(chres_we), .chres_chan(chres_chan), .chres_data(chres_data)
  );

  function automatic int pow2(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * 2;
    return r;
  endfunction

  function automatic int popc(input int m);
    int c = 0;
    for (int i = 0; i < 7; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic logic [5:0] lane(input int code);
    logic [5:0] v = '0;
    if (code >= 1 && code <= 6) v[code-1] = 1'b1;
    return v;
  endfunction

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: grant a request, answer after a random latency
  initial begin
    logic [2:0] cur;
    int lat;
    conv_grant = 1'b0;
    conv_done  = 1'b0;
    conv_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && conv_req) begin
        conv_grant = 1'b1;
        cur = conv_chan;
        @(negedge clk);
        conv_grant = 1'b0;
        lat = $urandom_range(0, 3);
        repeat (lat) @(negedge clk);
        conv_data = 11'($urandom);
        conv_done = 1'b1;
        #1;
        if (log_n < 256) begin
          log_chan[log_n] = cur;
          log_data[log_n] = conv_data;
          log_wr[log_n]   = chres_we;
          log_wrch[log_n] = chres_chan;
          log_wrd[log_n]  = chres_data;
        end
        log_n++;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic pulse_trig(input logic [5:0] lines);
    @(negedge clk);
    trig_in = lines;
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic wait_quiet();
    do @(negedge clk); while (sgl_active || seq_active || conv_req || conv_done);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    sgl_clr = 1; seq_clr = 1; sgl_res_rd = 1;
    @(negedge clk);
    sgl_clr = 0; seq_clr = 0; sgl_res_rd = 0;
  endtask

  task automatic run_case(input bit ds, input bit dq, input int ss, input int sq, input int ch,
                          input int rep, input int mask, input bit wt, input bit ies, input bit ieq);
    int ns, nq, idx;
    @(negedge clk);
    sgl_trig_sel = ds ? 3'(ss) : 3'd0;
    seq_trig_sel = dq ? 3'(sq) : 3'd0;
    sgl_chan_cfg = 3'(ch); sgl_rep_cfg = 3'(rep); seq_mask_cfg = 7'(mask);
    sgl_wait_rd = wt; sgl_ie = ies; seq_ie = ieq;
    sgl_res_rd = 1;
    @(negedge clk);
    sgl_res_rd = 0;
    chk_eq("R9 read clears valid", int'(sgl_res_valid), 0);
    chk_eq("R9 read clears overrun", int'(sgl_res_ovf), 0);
    log_n = 0;
    pulse_trig((ds ? lane(ss) : 6'd0) | (dq ? lane(sq) : 6'd0));
    ns = ds ? pow2(rep) : 0;
    nq = dq ? popc(mask) : 0;
    chk_eq("R6 single active after edge", int'(sgl_active), int'(ds));
    chk_eq("R6 sequence active after edge", int'(seq_active), int'(nq != 0));
    wait_quiet();
    chk_eq("R2 R3 conversion count", log_n, ns + nq);
    idx = 0;
    // R5: single-channel block first when both start together
    for (int i = 0; i < ns && idx < 256; i++) begin
      chk_eq("R2 single channel", int'(log_chan[idx]), ch);
      chk_eq("R8 no channel write for single", int'(log_wr[idx]), 0);
      idx++;
    end
    for (int b = 0; b < 7; b++) begin
      if (dq && mask[b] && idx < 256) begin
        chk_eq("R3 ascending channel", int'(log_chan[idx]), b);
        chk_eq("R8 channel write strobe", int'(log_wr[idx]), 1);
        chk_eq("R8 channel write number", int'(log_wrch[idx]), b);
        chk_eq("R8 channel write data", int'(log_wrd[idx]), int'(log_data[idx]));
        idx++;
      end
    end
    chk_eq("R9 result valid", int'(sgl_res_valid), int'(ds));
    if (ds && ns > 0) begin
      chk_eq("R9 result data", int'(sgl_res_data), int'(wt ? log_data[0] : log_data[ns-1]));
      chk_eq("R9 overrun", int'(sgl_res_ovf), int'(!wt && ns > 1));
    end
    chk_eq("R7 single status", int'(sgl_status), int'(ds));
    chk_eq("R7 single irq", int'(sgl_irq), int'(ds && ies));
    chk_eq("R7 sequence status", int'(seq_status), int'(nq != 0));
    chk_eq("R7 sequence irq", int'(seq_irq), int'(nq != 0 && ieq));
    clear_all();
    chk_eq("R7 single status cleared", int'(sgl_status), 0);
    chk_eq("R7 sequence status cleared", int'(seq_status), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int first_sgl, n_wr, prev_ch, ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_eq("R10 request idle", int'(conv_req), 0);
    chk_eq("R10 active flags", int'(sgl_active | seq_active), 0);
    chk_eq("R10 status and irq", int'(sgl_status | seq_status | sgl_irq | seq_irq), 0);
    chk_eq("R10 result empty", int'(sgl_res_valid | sgl_res_ovf), 0);
    chk_eq("R10 no channel write", int'(chres_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: codes 0 and 7 select nothing
    sgl_trig_sel = 3'd0; seq_trig_sel = 3'd7; seq_mask_cfg = 7'h7F; log_n = 0;
    pulse_trig(6'h3F);
    repeat (6) @(negedge clk);
    chk_eq("R1 code 0/7 no start", int'(sgl_active | seq_active), 0);
    chk_eq("R1 code 0/7 no conversion", log_n, 0);

    // R1: level held high starts only one run
    sgl_trig_sel = 3'd3; seq_trig_sel = 3'd0; sgl_rep_cfg = 3'd0; sgl_chan_cfg = 3'd1;
    log_n = 0;
    @(negedge clk); trig_in = 6'b000100;
    repeat (40) @(negedge clk);
    trig_in = '0;
    wait_quiet();
    chk_eq("R1 held level single run", log_n, 1);
    clear_all();

    // directed boundary runs
    run_case(1, 0, 6, 0, 5, 0, 0, 0, 1, 0);
    run_case(1, 0, 1, 0, 3, 7, 0, 1, 1, 1);
    run_case(1, 0, 2, 0, 7, 3, 0, 0, 0, 0);
    run_case(0, 1, 0, 4, 0, 0, 7'h7F, 0, 0, 1);
    run_case(0, 1, 0, 5, 0, 0, 7'h40, 0, 0, 1);
    run_case(0, 1, 0, 2, 0, 0, 7'h00, 0, 0, 1); // R3 zero mask ignored

    // R4: retrigger while active with changed settings
    sgl_trig_sel = 3'd2; seq_trig_sel = 3'd0; sgl_chan_cfg = 3'd4; sgl_rep_cfg = 3'd2;
    log_n = 0;
    pulse_trig(6'b000010);
    repeat (3) @(negedge clk);
    sgl_chan_cfg = 3'd6; sgl_rep_cfg = 3'd5;
    chk_eq("R4 still active before retrigger", int'(sgl_active), 1);
    pulse_trig(6'b000010);
    wait_quiet();
    chk_eq("R4 retrigger ignored count", log_n, 4);
    ok = 1;
    for (int i = 0; i < 4; i++) if (log_chan[i] != 3'd4) ok = 0;
    chk_eq("R4 captured channel kept", ok, 1);
    clear_all();

    sgl_trig_sel = 3'd0; seq_trig_sel = 3'd5; seq_mask_cfg = 7'h05; log_n = 0;
    pulse_trig(6'b010000);
    seq_mask_cfg = 7'h7F;
    pulse_trig(6'b010000);
    wait_quiet();
    chk_eq("R4 sequence retrigger ignored", log_n, 2);
    clear_all();

    // R5: single trigger during a sequence run slots in as one block
    sgl_trig_sel = 3'd4; seq_trig_sel = 3'd1; seq_mask_cfg = 7'h7F;
    sgl_chan_cfg = 3'd2; sgl_rep_cfg = 3'd1; log_n = 0;
    pulse_trig(6'b000001);
    do @(negedge clk); while (log_n < 2);
    pulse_trig(6'b001000);
    wait_quiet();
    chk_eq("R5 total with interleave", log_n, 9);
    first_sgl = -1; n_wr = 0; prev_ch = -1; ok = 1;
    for (int i = 0; i < 9 && i < log_n; i++) begin
      if (log_wr[i]) begin
        n_wr++;
        if (int'(log_chan[i]) <= prev_ch) ok = 0;
        prev_ch = int'(log_chan[i]);
      end else if (first_sgl < 0) first_sgl = i;
    end
    chk_eq("R5 sequence entries", n_wr, 7);
    chk_eq("R5 sequence stays ascending", ok, 1);
    chk_eq("R5 single block contiguous",
           int'(first_sgl >= 0 && first_sgl < 8 && !log_wr[first_sgl+1]), 1);
    clear_all();

    // random runs mixed with both-trigger priority cases
    for (int it = 0; it < 24; it++) begin
      bit ds, dq;
      int r;
      r  = $urandom_range(1, 3);
      ds = (r != 2);
      dq = (r != 1);
      run_case(ds, dq, $urandom_range(1, 6), $urandom_range(1, 6), $urandom_range(0, 7),
               $urandom_range(0, 6), $urandom_range(0, 127), 1'($urandom), 1'($urandom),
               1'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule